// File: doc/BRIEF.md
# Paired-Slot Register Conflict Resolver

Two instruction slots, an upper one and a lower one, issue together every cycle and share a vector register file and a clip-flag register. This block owns that storage. It also decides how the two slots interact when their register indices overlap. Each slot presents decoded source indices, a destination index, a write enable and a precomputed result; the arithmetic itself happens elsewhere. The block returns the operand values for both slots. It also decides whether the lower slot's results may be kept, and it writes the kept results back in a fixed order.

The vector file holds `NREG` entries of `DW` bits, with four read ports and two write ports. Entry 0 is constant zero. Both slots always read the state from before the current clock edge, so a same-cycle upper write never leaks into a lower operand. A lower slot that collides with the upper slot is cancelled as a whole. This happens when both slots write the same nonzero vector destination, or when the lower slot writes the clip flag that the upper slot reads. The block pulses `discard_o` on the following cycle. When the immediate flag is raised, the lower half of the instruction word carries a constant rather than an operation, so every lower-slot access is suppressed.

Top module: `vpair_resolver`

## Requirements
- R1: After reset every vector entry and the clip register read as zero, and `discard_o` is low.
- R2: Vector index 0 always reads zero. A write to index 0 from either slot is dropped and never counts as a collision, even when both slots name index 0.
- R3: Operand and clip outputs reflect register state from before the current rising edge. A committed write becomes visible from the cycle after its edge.
- R4: When a lower source operand (A or B) names the upper slot's nonzero destination, the lower slot receives the value from before the upper write. The lower slot still commits if nothing else collides.
- R5: When both slots write the same nonzero vector index, the lower slot is cancelled. `lo_commit_o` is 0, neither the lower vector write nor the lower clip write lands, and the upper result is written.
- R6: When the upper slot reads the clip flag and the lower slot writes it, the lower slot is cancelled, with the same effects as in R5.
- R7: When both slots read the clip flag, `lo_clip_o` gives the clip value from before the edge, even if the upper slot writes the clip flag in the same cycle.
- R8: While `imm_i` is 1, `lo_commit_o` is 0 and no lower write lands. `lo_rdata_a_o`, `lo_rdata_b_o` and `lo_clip_o` are zero, and no discard is raised.
- R9: `discard_o` is 1 in exactly the cycle after a cycle in which the lower slot was cancelled, and 0 otherwise.
- R10: When both slots commit a clip write in the same cycle, the lower slot's value is the one kept, because lower results are written back after upper ones.
- R11: Without `imm_i` and without a collision, `lo_commit_o` is 1 and both slots' writes land. `lo_clip_o` shows the clip register when `lo_clip_rd_i` is 1 and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imm_i | input | 1 | Immediate flag: lower slot holds no operation |
| up_src_a_i | input | AW | Upper source A index |
| up_src_b_i | input | AW | Upper source B index |
| up_we_i | input | 1 | Upper vector write enable |
| up_dst_i | input | AW | Upper vector destination index |
| up_wdata_i | input | DW | Upper vector result |
| up_clip_rd_i | input | 1 | Upper slot reads the clip flag |
| up_clip_we_i | input | 1 | Upper slot writes the clip flag |
| up_clip_wdata_i | input | CW | Upper clip result |
| lo_src_a_i | input | AW | Lower source A index |
| lo_src_b_i | input | AW | Lower source B index |
| lo_we_i | input | 1 | Lower vector write enable |
| lo_dst_i | input | AW | Lower vector destination index |
| lo_wdata_i | input | DW | Lower vector result |
| lo_clip_rd_i | input | 1 | Lower slot reads the clip flag |
| lo_clip_we_i | input | 1 | Lower slot writes the clip flag |
| lo_clip_wdata_i | input | CW | Lower clip result |
| up_rdata_a_o | output | DW | Upper operand A |
| up_rdata_b_o | output | DW | Upper operand B |
| lo_rdata_a_o | output | DW | Lower operand A |
| lo_rdata_b_o | output | DW | Lower operand B |
| up_clip_o | output | CW | Clip value seen by the upper slot |
| lo_clip_o | output | CW | Clip value seen by the lower slot |
| lo_commit_o | output | 1 | Lower slot results are kept this cycle |
| discard_o | output | 1 | Lower slot was cancelled in the previous cycle |

## Verification
A wrong collision decision shows up in two places. `lo_commit_o` is wrong in the same cycle, and `discard_o` is wrong one edge later. A stray or lost write stays hidden in the register file until some later read names that entry, so the bench reads back destinations soon after writing them. A write-order error or a leak between slots in the clip path shows on both clip outputs on the very next cycle, because the single clip register feeds both of them.

// File: rtl/vpair_pkg.sv
package vpair_pkg;
  typedef enum logic [1:0] {
    CF_NONE     = 2'd0,
    CF_VEC_DST  = 2'd1,
    CF_CLIP_RAW = 2'd2
  } cf_cause_e;
endpackage

// File: rtl/vpair_regfile.sv
module vpair_regfile #(
  parameter int NREG = 32,
  parameter int DW   = 128,
  parameter int NRD  = 4,
  parameter int NWR  = 2,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NRD-1:0][AW-1:0]   ra_i,
  output logic [NRD-1:0][DW-1:0]   rd_o,
  input  logic [NWR-1:0]           we_i,
  input  logic [NWR-1:0][AW-1:0]   wa_i,
  input  logic [NWR-1:0][DW-1:0]   wd_i
);
  logic [DW-1:0] mem_q [NREG];

  // later port index wins on an address tie
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else begin
      for (int p = 0; p < NWR; p++)
        if (we_i[p] && wa_i[p] != '0) mem_q[wa_i[p]] <= wd_i[p];
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_o[r] = (ra_i[r] == '0) ? '0 : mem_q[ra_i[r]];
  end

  // R5: resolver never lets both write ports hit one live entry
  a_r5_single_writer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i[0] && we_i[NWR-1] && wa_i[0] == wa_i[NWR-1] && wa_i[0] != '0));

  // R3: last write port lands on the next edge
  a_r3_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i[NWR-1] && wa_i[NWR-1] != '0) |=> mem_q[$past(wa_i[NWR-1])] == $past(wd_i[NWR-1]));

  // R2: entry 0 never changes
  a_r2_zero_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_q[0] == '0);
endmodule

// File: rtl/vpair_hazard.sv
module vpair_hazard
  import vpair_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          imm_i,
  input  logic          up_we_i,
  input  logic [AW-1:0] up_dst_i,
  input  logic          up_clip_rd_i,
  input  logic          lo_we_i,
  input  logic [AW-1:0] lo_dst_i,
  input  logic          lo_clip_we_i,
  output cf_cause_e     cause_o,
  output logic          lo_commit_o
);
  logic up_vec_live;
  logic vec_hit;
  logic clip_hit;

  assign up_vec_live = up_we_i && (up_dst_i != '0);
  assign vec_hit     = up_vec_live && lo_we_i && (lo_dst_i == up_dst_i);
  assign clip_hit    = up_clip_rd_i && lo_clip_we_i;

  always_comb begin
    cause_o = CF_NONE;
    if (!imm_i) begin
      if (vec_hit)       cause_o = CF_VEC_DST;
      else if (clip_hit) cause_o = CF_CLIP_RAW;
    end
  end

  assign lo_commit_o = !imm_i && (cause_o == CF_NONE);
endmodule

// File: rtl/vpair_clip.sv
module vpair_clip #(
  parameter int CW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          up_we_i,
  input  logic [CW-1:0] up_wdata_i,
  input  logic          lo_we_i,
  input  logic [CW-1:0] lo_wdata_i,
  output logic [CW-1:0] clip_o
);
  logic [CW-1:0] clip_q;

  // upper first, lower last
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clip_q <= '0;
    end else if (lo_we_i) begin
      clip_q <= lo_wdata_i;
    end else if (up_we_i) begin
      clip_q <= up_wdata_i;
    end
  end

  assign clip_o = clip_q;

  // R10: a kept lower clip write is the value that survives the edge
  a_r10_lower_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_we_i |=> clip_q == $past(lo_wdata_i));

  // R3: no write, no change
  a_r3_clip_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lo_we_i && !up_we_i) |=> $stable(clip_q));
endmodule

// File: rtl/vpair_resolver.sv
module vpair_resolver
  import vpair_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DW   = 128,
  parameter int CW   = 24,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          imm_i,
  input  logic [AW-1:0] up_src_a_i,
  input  logic [AW-1:0] up_src_b_i,
  input  logic          up_we_i,
  input  logic [AW-1:0] up_dst_i,
  input  logic [DW-1:0] up_wdata_i,
  input  logic          up_clip_rd_i,
  input  logic          up_clip_we_i,
  input  logic [CW-1:0] up_clip_wdata_i,
  input  logic [AW-1:0] lo_src_a_i,
  input  logic [AW-1:0] lo_src_b_i,
  input  logic          lo_we_i,
  input  logic [AW-1:0] lo_dst_i,
  input  logic [DW-1:0] lo_wdata_i,
  input  logic          lo_clip_rd_i,
  input  logic          lo_clip_we_i,
  input  logic [CW-1:0] lo_clip_wdata_i,
  output logic [DW-1:0] up_rdata_a_o,
  output logic [DW-1:0] up_rdata_b_o,
  output logic [DW-1:0] lo_rdata_a_o,
  output logic [DW-1:0] lo_rdata_b_o,
  output logic [CW-1:0] up_clip_o,
  output logic [CW-1:0] lo_clip_o,
  output logic          lo_commit_o,
  output logic          discard_o
);
  localparam int NRD = 4;
  localparam int NWR = 2;

  cf_cause_e              cause;
  logic                   commit;
  logic                   discard_q;
  logic [NRD-1:0][AW-1:0] ra;
  logic [NRD-1:0][DW-1:0] rd;
  logic [NWR-1:0]         we;
  logic [NWR-1:0][AW-1:0] wa;
  logic [NWR-1:0][DW-1:0] wd;
  logic [CW-1:0]          clip;

  vpair_hazard #(.AW(AW)) u_hazard (
    .imm_i       (imm_i),
    .up_we_i     (up_we_i),
    .up_dst_i    (up_dst_i),
    .up_clip_rd_i(up_clip_rd_i),
    .lo_we_i     (lo_we_i),
    .lo_dst_i    (lo_dst_i),
    .lo_clip_we_i(lo_clip_we_i),
    .cause_o     (cause),
    .lo_commit_o (commit)
  );

  assign ra = {lo_src_b_i, lo_src_a_i, up_src_b_i, up_src_a_i};
  // port 0 upper, port 1 lower: lower lands last
  assign we = {commit && lo_we_i, up_we_i};
  assign wa = {lo_dst_i, up_dst_i};
  assign wd = {lo_wdata_i, up_wdata_i};

  vpair_regfile #(.NREG(NREG), .DW(DW), .NRD(NRD), .NWR(NWR)) u_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ra_i  (ra),
    .rd_o  (rd),
    .we_i  (we),
    .wa_i  (wa),
    .wd_i  (wd)
  );

  vpair_clip #(.CW(CW)) u_clip (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .up_we_i   (up_clip_we_i),
    .up_wdata_i(up_clip_wdata_i),
    .lo_we_i   (commit && lo_clip_we_i),
    .lo_wdata_i(lo_clip_wdata_i),
    .clip_o    (clip)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) discard_q <= 1'b0;
    else         discard_q <= (cause != CF_NONE);
  end

  assign up_rdata_a_o = rd[0];
  assign up_rdata_b_o = rd[1];
  assign lo_rdata_a_o = imm_i ? '0 : rd[2];
  assign lo_rdata_b_o = imm_i ? '0 : rd[3];
  assign up_clip_o    = clip;
  assign lo_clip_o    = (!imm_i && lo_clip_rd_i) ? clip : '0;
  assign lo_commit_o  = commit;
  assign discard_o    = discard_q;

  // R9: pulse one cycle after a cancel, quiet otherwise
  a_r9_discard_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause != CF_NONE) |=> discard_o);
  a_r9_discard_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause == CF_NONE) |=> !discard_o);

  // R8: immediate word blocks every lower effect
  a_r8_imm_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imm_i |-> (!lo_commit_o && cause == CF_NONE && lo_clip_o == '0));

  // R5: a vector collision still lets the upper result land
  a_r5_upper_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause == CF_VEC_DST) |-> (we == 2'b01));
endmodule

// File: tb/sim_vpair_resolver.sv
`timescale 1ns/1ps
module sim_vpair_resolver;
  localparam int NREG = 32;
  localparam int DW   = 128;
  localparam int CW   = 24;
  localparam int AW   = $clog2(NREG);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          imm;
  logic [AW-1:0] up_a, up_b, up_dst, lo_a, lo_b, lo_dst;
  logic          up_we, lo_we, up_crd, up_cwe, lo_crd, lo_cwe;
  logic [DW-1:0] up_wd, lo_wd;
  logic [CW-1:0] up_cwd, lo_cwd;
  logic [DW-1:0] up_ra, up_rb, lo_ra, lo_rb;
  logic [CW-1:0] up_co, lo_co;
  logic          lo_commit, discard;

  vpair_resolver #(.NREG(NREG), .DW(DW), .CW(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .imm_i(imm),
    .up_src_a_i(up_a), .up_src_b_i(up_b), .up_we_i(up_we), .up_dst_i(up_dst),
    .up_wdata_i(up_wd), .up_clip_rd_i(up_crd), .up_clip_we_i(up_cwe),
    .up_clip_wdata_i(up_cwd),
    .lo_src_a_i(lo_a), .lo_src_b_i(lo_b), .lo_we_i(lo_we), .lo_dst_i(lo_dst),
    .lo_wdata_i(lo_wd), .lo_clip_rd_i(lo_crd), .lo_clip_we_i(lo_cwe),
    .lo_clip_wdata_i(lo_cwd),
    .up_rdata_a_o(up_ra), .up_rdata_b_o(up_rb),
    .lo_rdata_a_o(lo_ra), .lo_rdata_b_o(lo_rb),
    .up_clip_o(up_co), .lo_clip_o(lo_co),
    .lo_commit_o(lo_commit), .discard_o(discard)
  );

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] m_vf [NREG];
  logic [CW-1:0] m_clip;
  logic          exp_disc;
  logic          prev_both_clip;

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic logic [DW-1:0] rdm(logic [AW-1:0] a);
    return (a == '0) ? '0 : m_vf[a];
  endfunction

  function automatic logic [DW-1:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic idle();
    imm = 1'b0; up_a = '0; up_b = '0; up_dst = '0; lo_a = '0; lo_b = '0; lo_dst = '0;
    up_we = 1'b0; lo_we = 1'b0; up_crd = 1'b0; up_cwe = 1'b0; lo_crd = 1'b0; lo_cwe = 1'b0;
    up_wd = '0; lo_wd = '0; up_cwd = '0; lo_cwd = '0;
  endtask

  // inputs already driven after a negedge; check, clock, update model
  task automatic step();
    logic vcol, ccol, conf, commit, lo_hit_a, lo_hit_b, both_clip;
    string t;
    #2;
    vcol = !imm && up_we && up_dst != '0 && lo_we && lo_dst == up_dst;
    ccol = !imm && up_crd && lo_cwe;
    conf = vcol || ccol;
    commit = !imm && !conf;
    lo_hit_a = !imm && up_we && up_dst != '0 && lo_a == up_dst;
    lo_hit_b = !imm && up_we && up_dst != '0 && lo_b == up_dst;

    chk((up_a == '0) ? "R2 up_a" : "R3 up_a", up_ra, rdm(up_a));
    chk((up_b == '0) ? "R2 up_b" : "R3 up_b", up_rb, rdm(up_b));
    t = imm ? "R8 lo_a" : (lo_hit_a ? "R4 lo_a" : "R3 lo_a");
    chk(t, lo_ra, imm ? '0 : rdm(lo_a));
    t = imm ? "R8 lo_b" : (lo_hit_b ? "R4 lo_b" : "R3 lo_b");
    chk(t, lo_rb, imm ? '0 : rdm(lo_b));
    chk(prev_both_clip ? "R10 up_clip" : "R3 up_clip", DW'(up_co), DW'(m_clip));
    t = imm ? "R8 lo_clip" : ((up_crd && lo_crd) ? "R7 lo_clip" : "R11 lo_clip");
    chk(t, DW'(lo_co), DW'((!imm && lo_crd) ? m_clip : '0));
    t = imm ? "R8 commit" : (vcol ? "R5 commit" : (ccol ? "R6 commit" : "R11 commit"));
    chk(t, DW'(lo_commit), DW'(commit));
    chk("R9 discard", DW'(discard), DW'(exp_disc));

    @(posedge clk);
    both_clip = up_cwe && commit && lo_cwe;
    if (up_we && up_dst != '0) m_vf[up_dst] = up_wd;
    if (commit && lo_we && lo_dst != '0) m_vf[lo_dst] = lo_wd;
    if (up_cwe) m_clip = up_cwd;
    if (commit && lo_cwe) m_clip = lo_cwd;
    exp_disc = conf;
    prev_both_clip = both_clip;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=running exp=done");
    report();
  end

  initial begin
    for (int i = 0; i < NREG; i++) m_vf[i] = '0;
    m_clip = '0; exp_disc = 1'b0; prev_both_clip = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset contents
    for (int i = 0; i < NREG; i += 4) begin
      up_a = AW'(i); up_b = AW'(i + 1); lo_a = AW'(i + 2); lo_b = AW'(i + 3);
      #1;
      chk("R1 reset a", up_ra, '0);
      chk("R1 reset b", lo_rb, '0);
      step();
    end
    chk("R1 reset clip", DW'(up_co), '0);

    // fill 1..4 by upper while imm hides a lower write to 5 (R8)
    for (int i = 1; i <= 4; i++) begin
      idle(); imm = 1'b1; up_we = 1'b1; up_dst = AW'(i); up_wd = rnd128();
      lo_we = 1'b1; lo_dst = 5; lo_wd = rnd128(); lo_cwe = 1'b1; lo_cwd = 24'hABCDEF;
      lo_a = AW'(i); lo_crd = 1'b1;
      step();
    end
    idle(); up_a = 5; step();

    // R2: both write index 0
    idle(); up_we = 1'b1; lo_we = 1'b1; up_wd = rnd128(); lo_wd = rnd128(); step();
    idle(); lo_a = 0; up_b = 0; step();

    // R4: lower reads upper destination on both operands
    idle(); up_we = 1'b1; up_dst = 1; up_wd = rnd128(); lo_a = 1; lo_b = 1;
    lo_we = 1'b1; lo_dst = 2; lo_wd = rnd128(); step();
    idle(); up_a = 1; up_b = 2; step();

    // R5: same destination
    idle(); up_we = 1'b1; up_dst = 3; up_wd = rnd128();
    lo_we = 1'b1; lo_dst = 3; lo_wd = rnd128(); lo_cwe = 1'b1; lo_cwd = 24'h111111; step();
    idle(); up_a = 3; step();

    // R6: upper reads clip, lower writes it
    idle(); up_cwe = 1'b1; up_cwd = 24'h0000F0; step();
    idle(); up_crd = 1'b1; lo_cwe = 1'b1; lo_cwd = 24'h222222;
    lo_we = 1'b1; lo_dst = 4; lo_wd = rnd128(); step();
    idle(); up_a = 4; step();

    // R7: both read clip while upper writes it
    idle(); up_crd = 1'b1; lo_crd = 1'b1; up_cwe = 1'b1; up_cwd = 24'h333333; step();
    idle(); lo_crd = 1'b1; step();

    // R10: both write clip, lower wins
    idle(); up_cwe = 1'b1; up_cwd = 24'h444444; lo_cwe = 1'b1; lo_cwd = 24'h555555; step();
    idle(); step();

    // mixed traffic on a small index set to force overlaps
    for (int n = 0; n < 600; n++) begin
      imm = ($urandom_range(0, 7) == 0);
      up_a = AW'($urandom_range(0, 3)); up_b = AW'($urandom_range(0, 3));
      lo_a = AW'($urandom_range(0, 3)); lo_b = AW'($urandom_range(0, 3));
      up_dst = AW'($urandom_range(0, 3)); lo_dst = AW'($urandom_range(0, 3));
      up_we = 1'($urandom_range(0, 1)); lo_we = 1'($urandom_range(0, 1));
      up_crd = 1'($urandom_range(0, 1)); lo_crd = 1'($urandom_range(0, 1));
      up_cwe = 1'($urandom_range(0, 1)); lo_cwe = 1'($urandom_range(0, 1));
      up_wd = rnd128(); lo_wd = rnd128();
      up_cwd = CW'($urandom); lo_cwd = CW'($urandom);
      step();
    end
    idle(); step();
    report();
  end
endmodule